// File: doc/BRIEF.md
# Hypervisor-Aware Physical Memory Protection Checker

This block decides whether a data access from a RISC-V hart with the hypervisor extension may touch a given physical address. It first resolves the privilege that governs the access. Hypervisor load and store instructions take a guest privilege chosen by the hypervisor-status previous-privilege bit. Ordinary accesses may be redirected by the modify-privilege bit of the machine status register. The physical address is then tested against a bank of protection entries, and the block reports either an allow or an access fault with its exception cause.

The check is purely combinational. The surrounding pipeline presents the access attributes and the current protection register contents, and it reads `fault` and `cause` in the same cycle. There is no handshake: every input is a level, and the outputs follow the inputs after logic delay only.

Each entry has an 8-bit configuration byte and a 32-bit address word. The address word holds physical address bits 33:2. In the configuration byte:

- bit 0 is read permission, bit 1 is write permission and bit 2 is execute permission, which this block does not use.
- bits 4:3 select the match mode: 0 off, 1 top-of-range, 2 single naturally aligned word, 3 naturally aligned power-of-two region.
- bit 7 is the lock.

Privilege encoding is 0 user, 1 supervisor, 3 machine. The access kind encoding is 0 ordinary load, 1 ordinary store, 2 hypervisor load and 3 hypervisor store. Bit 0 of the kind therefore marks a store, and bit 1 marks a hypervisor access.

Top module: `pmpx_guard`

## Requirements
- R1: A hypervisor access (kind 2 or 3) is checked at guest privilege: user-level when `spvp` is 0 and supervisor-level when `spvp` is 1. This privilege is never machine level, whatever the values of `cur_priv`, `mprv` and `mpp`.
- R2: An ordinary access issued while `cur_priv` is 3 with `mprv` set takes `mpp` as its privilege. In every other case an ordinary access uses `cur_priv`.
- R3: An entry whose lock bit is clear never restricts an access of machine privilege. An entry whose lock bit is set applies its permissions to machine accesses as well.
- R4: When several entries match, only the matching entry with the lowest index decides the outcome.
- R5: In power-of-two mode, t trailing one bits in the address word give a region of 2^(t+3) bytes. The access matches when the word-address bits above bit t agree with the entry. An address word of all ones covers the whole space.
- R6: In top-of-range mode, entry i matches word addresses w with prev <= w < this. Here prev is the address word of entry i-1, even when that entry is off, and it is 0 for entry 0. If prev >= this, the entry matches nothing.
- R7: In single-word mode, an entry matches only the one word equal to its address word.
- R8: An entry in off mode matches nothing. Its address word still serves as the lower bound of the next entry.
- R9: When no entry matches, a machine-privilege access is allowed. Any other access faults if at least one entry is not off, and is allowed if every entry is off.
- R10: A matched load needs the read bit and a matched store needs the write bit. The execute bit plays no part.
- R11: A faulting load or hypervisor load reports cause 5. A faulting store or hypervisor store reports cause 7. When there is no fault, `cause` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_priv | input | 2 | Current hart privilege (0 U, 1 S, 3 M) |
| mprv | input | 1 | Machine status modify-privilege bit |
| mpp | input | 2 | Machine status previous-privilege field |
| spvp | input | 1 | Hypervisor status previous-privilege bit (0 user, 1 supervisor guest) |
| acc_kind | input | 2 | Access kind: 0 load, 1 store, 2 hypervisor load, 3 hypervisor store |
| paddr | input | PA_W (34) | Physical byte address of the access |
| pmpcfg_flat | input | N_ENT*8 (128) | Configuration bytes, entry i in bits 8i+7:8i |
| pmpaddr_flat | input | N_ENT*(PA_W-2) (512) | Address words, entry i in bits 32i+31:32i |
| fault | output | 1 | Access is denied |
| cause | output | 5 | Exception cause for a denied access, else 0 |

## Verification
The assertions check the cause encoding for every input combination at all times (R11). They also check that a bank with every entry off never faults (R9). A third check covers machine accesses that bypass the bank: without a lock bit set anywhere, an ordinary non-redirected machine access never faults (R3). Some behaviour depends on a reference outcome across many combinations and is left to the bench. This covers the guest privilege used by hypervisor accesses while the hart sits in machine mode, lowest-index priority, and the region boundaries of each match mode. The bench sweeps every privilege, redirect and access-kind combination against arithmetically built entry layouts.

// File: rtl/pmpx_pkg.sv
package pmpx_pkg;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [1:0] AM_OFF   = 2'd0;
  localparam logic [1:0] AM_TOR   = 2'd1;
  localparam logic [1:0] AM_WORD  = 2'd2;
  localparam logic [1:0] AM_POW2  = 2'd3;

  localparam logic [4:0] CAUSE_LD_FAULT = 5'd5;
  localparam logic [4:0] CAUSE_ST_FAULT = 5'd7;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    logic [1:0] amode;
    logic       xp;
    logic       wp;
    logic       rp;
  } ent_cfg_t;

endpackage

// File: rtl/pmpx_priv_resolve.sv
module pmpx_priv_resolve
  import pmpx_pkg::*;
(
  input  logic [1:0] cur_priv,
  input  logic       mprv,
  input  logic [1:0] mpp,
  input  logic       spvp,
  input  logic [1:0] acc_kind,
  output logic       eff_is_m,
  output logic       is_store
);
  logic [1:0] eff_priv;

  always_comb begin
    if (acc_kind[1]) begin
      // guest access: privilege chosen by spvp, redirect bit ignored
      eff_priv = spvp ? PRIV_S : PRIV_U;
    end else if (cur_priv == PRIV_M && mprv) begin
      eff_priv = mpp;
    end else begin
      eff_priv = cur_priv;
    end
  end

  assign eff_is_m = (eff_priv == PRIV_M);
  assign is_store = acc_kind[0];
endmodule

// File: rtl/pmpx_entry_match.sv
module pmpx_entry_match
  import pmpx_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] word,
  input  logic [AW-1:0] lo_bound,
  input  logic [AW-1:0] entry_addr,
  input  logic [1:0]    amode,
  output logic          hit
);
  logic [AW-1:0] inc;
  logic [AW-1:0] care;

  assign inc  = entry_addr + {{(AW-1){1'b0}}, 1'b1};
  // trailing ones plus the first zero are don't-care bits
  assign care = ~(entry_addr ^ inc);

  always_comb begin
    unique case (amode)
      AM_TOR:  hit = (word >= lo_bound) && (word < entry_addr);
      AM_WORD: hit = (word == entry_addr);
      AM_POW2: hit = ((word & care) == (entry_addr & care));
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pmpx_prio_select.sv
module pmpx_prio_select #(
  parameter int N = 16
) (
  input  logic [N-1:0] hit,
  input  logic [N-1:0] lock,
  input  logic [N-1:0] rd_ok,
  input  logic [N-1:0] wr_ok,
  input  logic [N-1:0] active,
  input  logic         eff_is_m,
  input  logic         is_store,
  output logic         deny
);
  logic [N-1:0] neg;
  logic [N-1:0] first;
  logic         any_hit;
  logic         sel_lock;
  logic         sel_perm;

  // isolate the lowest set bit: that entry has priority
  assign neg      = ~hit + {{(N-1){1'b0}}, 1'b1};
  assign first    = hit & neg;
  assign any_hit  = |hit;
  assign sel_lock = |(first & lock);
  assign sel_perm = is_store ? |(first & wr_ok) : |(first & rd_ok);

  always_comb begin
    if (any_hit) begin
      deny = (eff_is_m && !sel_lock) ? 1'b0 : !sel_perm;
    end else begin
      deny = eff_is_m ? 1'b0 : (|active);
    end
  end
endmodule

// File: rtl/pmpx_guard.sv
module pmpx_guard
  import pmpx_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int PA_W  = 34
) (
  input  logic [1:0]              cur_priv,
  input  logic                    mprv,
  input  logic [1:0]              mpp,
  input  logic                    spvp,
  input  logic [1:0]              acc_kind,
  input  logic [PA_W-1:0]         paddr,
  input  logic [N_ENT*8-1:0]      pmpcfg_flat,
  input  logic [N_ENT*(PA_W-2)-1:0] pmpaddr_flat,
  output logic                    fault,
  output logic [4:0]              cause
);
  localparam int AW = PA_W - 2;

  logic [AW-1:0]    word;
  logic [N_ENT-1:0] hit, lock, rd_ok, wr_ok, active;
  logic [N_ENT-1:0] spare_unused;
  logic             eff_is_m, is_store, deny;
  logic [AW-1:0]    ent_addr [N_ENT];

  assign word = paddr[PA_W-1:2];

  pmpx_priv_resolve u_priv (
    .cur_priv (cur_priv),
    .mprv     (mprv),
    .mpp      (mpp),
    .spvp     (spvp),
    .acc_kind (acc_kind),
    .eff_is_m (eff_is_m),
    .is_store (is_store)
  );

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    ent_cfg_t      cfg;
    logic [AW-1:0] lo;

    assign cfg         = ent_cfg_t'(pmpcfg_flat[i*8 +: 8]);
    assign ent_addr[i] = pmpaddr_flat[i*AW +: AW];
    assign lock[i]     = cfg.lock;
    assign rd_ok[i]    = cfg.rp;
    assign wr_ok[i]    = cfg.wp;
    assign active[i]   = (cfg.amode != AM_OFF);
    assign spare_unused[i] = ^{cfg.xp, cfg.rsvd};

    if (i == 0) begin : g_base
      assign lo = '0;
    end else begin : g_prev
      assign lo = ent_addr[i-1];
    end

    pmpx_entry_match #(.AW(AW)) u_match (
      .word       (word),
      .lo_bound   (lo),
      .entry_addr (ent_addr[i]),
      .amode      (cfg.amode),
      .hit        (hit[i])
    );
  end

  pmpx_prio_select #(.N(N_ENT)) u_sel (
    .hit      (hit),
    .lock     (lock),
    .rd_ok    (rd_ok),
    .wr_ok    (wr_ok),
    .active   (active),
    .eff_is_m (eff_is_m),
    .is_store (is_store),
    .deny     (deny)
  );

  assign fault = deny;
  assign cause = deny ? (is_store ? CAUSE_ST_FAULT : CAUSE_LD_FAULT) : 5'd0;
endmodule

// File: rtl/pmpx_guard_chk.sv
module pmpx_guard_chk #(
  parameter int N_ENT = 16,
  parameter int PA_W  = 34
) (
  input logic [1:0]                cur_priv,
  input logic                      mprv,
  input logic [1:0]                acc_kind,
  input logic [N_ENT*8-1:0]        pmpcfg_flat,
  input logic                      fault,
  input logic [4:0]                cause
);
  logic any_on, any_locked;

  always_comb begin
    any_on     = 1'b0;
    any_locked = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      if (pmpcfg_flat[i*8+3 +: 2] != 2'd0) any_on = 1'b1;
      if (pmpcfg_flat[i*8+7]) any_locked = 1'b1;
    end
  end

  always_comb begin
    AST_LOAD_CAUSE:  assert (!(fault && !acc_kind[0]) || cause == 5'd5) else $error("load cause"); // R11
    AST_STORE_CAUSE: assert (!(fault && acc_kind[0]) || cause == 5'd7) else $error("store cause"); // R11
    AST_QUIET_CAUSE: assert (fault || cause == 5'd0) else $error("cause without fault"); // R11
    AST_ALL_OFF_OPEN: assert (any_on || !fault) else $error("fault with empty bank"); // R9
    AST_M_BYPASS: assert (!(!acc_kind[1] && cur_priv == 2'b11 && !mprv && !any_locked) || !fault) else $error("machine access denied by unlocked bank"); // R3
  end
endmodule

bind pmpx_guard pmpx_guard_chk #(.N_ENT(N_ENT), .PA_W(PA_W)) u_chk (
  .cur_priv    (cur_priv),
  .mprv        (mprv),
  .acc_kind    (acc_kind),
  .pmpcfg_flat (pmpcfg_flat),
  .fault       (fault),
  .cause       (cause)
);

// File: tb/test_pmpx_guard.sv
module test_pmpx_guard;
  localparam int N  = 16;
  localparam int PW = 34;
  localparam int AW = PW - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]      cur_priv = 2'd0;
  logic            mprv = 1'b0;
  logic [1:0]      mpp = 2'd0;
  logic            spvp = 1'b0;
  logic [1:0]      acc_kind = 2'd0;
  logic [PW-1:0]   paddr = '0;
  logic [7:0]      cfg_b [N];
  logic [AW-1:0]   adr_b [N];
  logic [N*8-1:0]  pmpcfg_flat;
  logic [N*AW-1:0] pmpaddr_flat;
  logic            fault;
  logic [4:0]      cause;

  int total = 0;
  int bad = 0;

  initial begin
    for (int i = 0; i < N; i++) begin
      cfg_b[i] = 8'h00;
      adr_b[i] = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      pmpcfg_flat[i*8 +: 8]   = cfg_b[i];
      pmpaddr_flat[i*AW +: AW] = adr_b[i];
    end
  end

  pmpx_guard #(.N_ENT(N), .PA_W(PW)) i_pmpx_guard (
    .cur_priv     (cur_priv),
    .mprv         (mprv),
    .mpp          (mpp),
    .spvp         (spvp),
    .acc_kind     (acc_kind),
    .paddr        (paddr),
    .pmpcfg_flat  (pmpcfg_flat),
    .pmpaddr_flat (pmpaddr_flat),
    .fault        (fault),
    .cause        (cause)
  );

  function automatic bit ref_hit(int i, logic [AW-1:0] w);
    logic [63:0] lo, hi, ww;
    int t;
    ww = 64'(w);
    hi = 64'(adr_b[i]);
    case (cfg_b[i][4:3])
      2'd1: begin
        lo = (i == 0) ? 64'd0 : 64'(adr_b[i-1]);
        return (ww >= lo) && (ww < hi);
      end
      2'd2: return ww == hi;
      2'd3: begin
        t = 0;
        while (t < AW && adr_b[i][t]) t++;
        if (t + 1 >= AW) return 1'b1;
        return (ww >> (t + 1)) == (hi >> (t + 1));
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit ref_fault(logic [1:0] cp, logic mr, logic [1:0] pp,
                                   logic [1:0] k, logic [PW-1:0] pa);
    bit m_level;
    bit on;
    logic [AW-1:0] w;
    w = pa[PW-1:2];
    if (k[1]) m_level = 1'b0;
    else if (cp == 2'd3 && mr) m_level = (pp == 2'd3);
    else m_level = (cp == 2'd3);
    for (int i = 0; i < N; i++) begin
      if (ref_hit(i, w)) begin
        if (m_level && !cfg_b[i][7]) return 1'b0;
        return k[0] ? !cfg_b[i][1] : !cfg_b[i][0];
      end
    end
    if (m_level) return 1'b0;
    on = 1'b0;
    for (int i = 0; i < N; i++) if (cfg_b[i][4:3] != 2'd0) on = 1'b1;
    return on;
  endfunction

  task automatic probe(string req, logic [1:0] cp, logic mr, logic [1:0] pp, logic sv,
                       logic [1:0] k, logic [PW-1:0] pa, bit exp_f);
    logic [4:0] exp_c;
    @(posedge clk);
    cur_priv = cp; mprv = mr; mpp = pp; spvp = sv; acc_kind = k; paddr = pa;
    @(negedge clk);
    exp_c = exp_f ? (k[0] ? 5'd7 : 5'd5) : 5'd0;
    total++;
    if (fault !== exp_f || cause !== exp_c) begin
      bad++;
      $display("FAIL %s: priv=%0d mprv=%0b mpp=%0d spvp=%0b kind=%0d addr=%h fault=%0b cause=%0d expected fault=%0b cause=%0d",
               req, cp, mr, pp, sv, k, pa, fault, cause, exp_f, exp_c);
    end
  endtask

  task automatic sweep(string req, logic [PW-1:0] pa);
    logic [1:0] lv [3];
    lv[0] = 2'd0; lv[1] = 2'd1; lv[2] = 2'd3;
    for (int a = 0; a < 3; a++)
      for (int r = 0; r < 2; r++)
        for (int b = 0; b < 3; b++)
          for (int s = 0; s < 2; s++)
            for (int k = 0; k < 4; k++)
              probe(req, lv[a], r[0], lv[b], s[0], k[1:0], pa,
                    ref_fault(lv[a], r[0], lv[b], k[1:0], pa));
  endtask

  function automatic logic [PW-1:0] wa(logic [AW-1:0] w);
    return {w, 2'b00};
  endfunction

  task automatic clear_bank();
    for (int i = 0; i < N; i++) begin
      cfg_b[i] = 8'h00;
      adr_b[i] = '0;
    end
  endtask

  initial begin
    #200_000_0;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // empty bank: everything allowed (R9)
    probe("R9 empty bank user load", 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, 34'h0_8000_1000, 1'b0);
    sweep("R9 empty bank", 34'h1_2345_6788);

    // unlocked no-access page at 0x8000_1000 (4 KiB), entry 1 allow-all
    adr_b[0] = 32'h2000_05FF; cfg_b[0] = 8'h18;
    adr_b[1] = 32'hFFFF_FFFF; cfg_b[1] = 8'h1F;
    probe("R1 M-mode hyp load spvp=0",   2'd3, 1'b0, 2'd3, 1'b0, 2'd2, 34'h0_8000_1010, 1'b1);
    probe("R1 M-mode hyp load spvp=1 mprv ignored", 2'd3, 1'b1, 2'd3, 1'b1, 2'd2, 34'h0_8000_1010, 1'b1);
    probe("R11 hyp store cause 7",       2'd3, 1'b0, 2'd3, 1'b0, 2'd3, 34'h0_8000_1ffc, 1'b1);
    probe("R3 M load bypasses unlocked", 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 34'h0_8000_1010, 1'b0);
    probe("R2 M mprv mpp=U load",        2'd3, 1'b1, 2'd0, 1'b0, 2'd0, 34'h0_8000_1010, 1'b1);
    probe("R2 M mprv mpp=M load",        2'd3, 1'b1, 2'd3, 1'b0, 2'd0, 34'h0_8000_1010, 1'b0);
    probe("R4 outside page entry 1",     2'd0, 1'b0, 2'd0, 1'b0, 2'd1, 34'h0_8000_2000, 1'b0);
    sweep("R1 R2 R5 page first word", 34'h0_8000_1000);
    sweep("R5 page last word",  34'h0_8000_1ffc);
    sweep("R5 below page",      34'h0_8000_0ffc);
    sweep("R5 above page",      34'h0_8000_2000);

    // locked deny applies to machine privilege (R3)
    cfg_b[0] = 8'h98;
    probe("R3 locked deny on M load", 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 34'h0_8000_1010, 1'b1);
    sweep("R3 locked", 34'h0_8000_1800);

    // top-of-range, single word, off (R6 R7 R8 R10)
    clear_bank();
    adr_b[0] = 32'h100; cfg_b[0] = 8'h09;
    adr_b[1] = 32'h180; cfg_b[1] = 8'h00;
    adr_b[2] = 32'h200; cfg_b[2] = 8'h0B;
    adr_b[3] = 32'h300; cfg_b[3] = 8'h12;
    adr_b[4] = 32'h050; cfg_b[4] = 8'h0F;
    probe("R6 entry 0 from zero load",   2'd0, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h0), 1'b0);
    probe("R10 read-only store",         2'd0, 1'b0, 2'd0, 1'b0, 2'd1, wa(32'h0), 1'b1);
    probe("R6 upper bound exclusive",    2'd0, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h100), 1'b1);
    probe("R9 M no match",               2'd3, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h100), 1'b0);
    probe("R8 off entry bound",          2'd1, 1'b0, 2'd0, 1'b0, 2'd1, wa(32'h180), 1'b0);
    probe("R7 word store",               2'd0, 1'b0, 2'd0, 1'b0, 2'd1, wa(32'h300), 1'b0);
    probe("R7 word load",                2'd0, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h300), 1'b1);
    probe("R7 next word unmatched",      2'd0, 1'b0, 2'd0, 1'b0, 2'd1, wa(32'h301), 1'b1);
    probe("R6 empty range",              2'd0, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h320), 1'b1);
    begin
      logic [AW-1:0] pts [12];
      pts = '{32'h0, 32'h1, 32'h40, 32'hFF, 32'h100, 32'h17F,
              32'h180, 32'h1FF, 32'h200, 32'h2FF, 32'h300, 32'h301};
      for (int p = 0; p < 12; p++) sweep("R6 R7 R8 R10 range map", wa(pts[p]));
    end

    // power-of-two sizes (R5)
    clear_bank();
    adr_b[0] = 32'h1000; cfg_b[0] = 8'h19;
    adr_b[1] = 32'h2007; cfg_b[1] = 8'h1A;
    begin
      logic [AW-1:0] pts [8];
      pts = '{32'hFFF, 32'h1000, 32'h1001, 32'h1002,
              32'h1FFF, 32'h2000, 32'h200F, 32'h2010};
      for (int p = 0; p < 8; p++) sweep("R5 region size", wa(pts[p]));
    end

    // priority (R4)
    clear_bank();
    adr_b[0] = 32'h500; cfg_b[0] = 8'h10;
    adr_b[1] = 32'h500; cfg_b[1] = 8'h13;
    probe("R4 low index deny wins", 2'd0, 1'b0, 2'd0, 1'b0, 2'd0, wa(32'h500), 1'b1);
    cfg_b[0] = 8'h13; cfg_b[1] = 8'h10;
    probe("R4 low index allow wins", 2'd0, 1'b0, 2'd0, 1'b0, 2'd1, wa(32'h500), 1'b0);
    sweep("R4 priority", wa(32'h500));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule